// File: doc/BRIEF.md
# Fetch-Triggered Expansion ROM Pager and Port Decoder

This block sits on the sampled bus of an 8-bit Z80-style processor inside an expansion interface. It watches opcode fetches. A fetch from one of two entry addresses maps the interface's own ROM and RAM over the host's low memory and disables the host ROM. A fetch from an exit address gives the host ROM back. There is no control register: software enters the interface by jumping to a trap address and leaves it by executing code at the exit address.

While mapped in, reads in the lower 8 KB window select a 4 KB interface ROM, which appears twice. Any access in the next 8 KB window selects a small interface RAM, which is mirrored across that window. The block also decodes one 8-bit I/O port on the low address byte. A write latches the data bus into an output register and pulses an active-low write strobe. A read pulses an active-low strobe that enables an external input buffer.

Bus control inputs are active low, as on the processor. The paging state is registered on the clock edge that ends the fetch cycle. The selects and strobes are combinational from the current bus inputs and that state.

Top module: `xpg_decoder`

## Requirements
- R1: While reset is asserted and afterwards until a page-in fetch, the block is mapped out: host_rom_dis is 0, rom_sel_n and ram_sel_n are 1, and port_q is 0.
- R2: A cycle with m1_n=0 and mreq_n=0 at address 0x0000 or 0x0008 sets the mapped-in state from the next clock edge onward.
- R3: A cycle with m1_n=0 and mreq_n=0 at address 0x0604 clears the mapped-in state from the next clock edge onward. Fetches at any other address leave the state unchanged.
- R4: Memory reads or writes at 0x0000, 0x0008 or 0x0604 with m1_n=1 do not change the mapped state.
- R5: While mapped in, rom_sel_n is 0 exactly when mreq_n=0, rd_n=0 and address bits 15:13 are 000. A write never selects the ROM. rom_addr equals address bits 11:0, so the 4 KB ROM repeats twice in the window.
- R6: While mapped in, ram_sel_n is 0 exactly when mreq_n=0 and address bits 15:13 are 001, for reads and for writes. ram_addr equals address bits 10:0, so the 2 KB RAM repeats four times.
- R7: The port decodes when the low address byte is 0xEF. Address bits 15:8 are ignored. Any other low byte, including 0xFF and 0xEE, never strobes.
- R8: port_wr_n is 0 exactly when iorq_n=0, wr_n=0, m1_n=1 and the port matches. port_rd_n is 0 exactly when iorq_n=0, rd_n=0, m1_n=1 and the port matches.
- R9: A cycle with iorq_n=0 and m1_n=0 (interrupt acknowledge) never drives port_wr_n or port_rd_n low.
- R10: port_q loads the data bus on the clock edge that ends a cycle with port_wr_n=0, and holds its value at every other edge.
- R11: host_rom_dis equals the mapped-in state in every cycle, independent of the current bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Sampled CPU address bus |
| din | input | 8 | Sampled CPU data bus for port writes |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge cycle, active low |
| rd_n | input | 1 | Read, active low |
| wr_n | input | 1 | Write, active low |
| host_rom_dis | output | 1 | High while the host ROM is disconnected |
| rom_sel_n | output | 1 | Interface ROM chip select, active low |
| rom_addr | output | 12 | Interface ROM address |
| ram_sel_n | output | 1 | Interface RAM chip select, active low |
| ram_addr | output | 11 | Interface RAM address |
| port_wr_n | output | 1 | Port write strobe, active low |
| port_rd_n | output | 1 | Port read strobe, enables the input buffer, active low |
| port_q | output | 8 | Latched port output register |

## Verification
The bench builds the block with its default parameters: a 4 KB ROM, a 2 KB RAM, port byte 0xEF, and low-byte-only port decoding. These sizes give two ROM images and four RAM images within their windows. Addresses such as 0x1234 and 0x3FFF therefore test the mirroring directly against the truncated addresses. Because the port decoder ignores the high byte, addresses like 0x12EF and 0xFFEF must strobe, while 0x00EE and 0x00FF must not. Directed sequences cover page-in, page-out and non-fetch accesses at the trap addresses. A constrained random phase then mixes the trap addresses, both windows and port addresses with every control combination.

// File: rtl/xpg_pkg.sv
package xpg_pkg;
   // decoded bus phase, active-high view of the CPU strobes
   typedef struct packed {
      logic mem;
      logic io;
      logic fetch;
      logic rd;
      logic wr;
   } xpg_ctl_t;

   function automatic xpg_ctl_t xpg_decode_ctl(input logic mreq_n, input logic iorq_n,
                                               input logic m1_n, input logic rd_n,
                                               input logic wr_n);
      xpg_ctl_t c;
      c.mem   = ~mreq_n;
      c.io    = ~iorq_n;
      c.fetch = ~m1_n;
      c.rd    = ~rd_n;
      c.wr    = ~wr_n;
      return c;
   endfunction
endpackage

// File: rtl/xpg_fetch_pager.sv
module xpg_fetch_pager
   import xpg_pkg::*;
#(
   parameter int          ADDR_W  = 16,
   parameter logic [15:0] ENTRY_A = 16'h0000,
   parameter logic [15:0] ENTRY_B = 16'h0008,
   parameter logic [15:0] EXIT_A  = 16'h0604,
   parameter int          SEL_BIT = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  xpg_ctl_t          ctl,
   output logic              paged
);
   logic trap_hit;

   initial begin
      if (ENTRY_A[SEL_BIT] || ENTRY_B[SEL_BIT] || !EXIT_A[SEL_BIT])
         $error("xpg_fetch_pager: selector bit must be 0 for entry and 1 for exit");
   end

   // the flop loads the inverse of one address bit, clocked only on trap fetches
   always_comb begin
      trap_hit = ctl.fetch && ctl.mem &&
                 ((addr == ENTRY_A[ADDR_W-1:0]) || (addr == ENTRY_B[ADDR_W-1:0]) ||
                  (addr == EXIT_A[ADDR_W-1:0]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        paged <= 1'b0;
      else if (trap_hit) paged <= ~addr[SEL_BIT];
   end
endmodule

// File: rtl/xpg_mem_sel.sv
module xpg_mem_sel
   import xpg_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int WIN_W     = 13,
   parameter int ROM_BYTES = 4096,
   parameter int RAM_BYTES = 2048,
   localparam int ROM_AW   = $clog2(ROM_BYTES),
   localparam int RAM_AW   = $clog2(RAM_BYTES),
   localparam int TAG_W    = ADDR_W - WIN_W
) (
   input  logic              paged,
   input  logic [ADDR_W-1:0] addr,
   input  xpg_ctl_t          ctl,
   output logic              rom_sel_n,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              ram_sel_n,
   output logic [RAM_AW-1:0] ram_addr
);
   localparam logic [TAG_W-1:0] ROM_TAG = '0;
   localparam logic [TAG_W-1:0] RAM_TAG = TAG_W'(1);

   initial begin
      if (ROM_AW > WIN_W || RAM_AW > WIN_W)
         $error("xpg_mem_sel: device larger than its window");
   end

   logic [TAG_W-1:0] tag;

   always_comb begin
      tag       = addr[ADDR_W-1:WIN_W];
      rom_sel_n = ~(paged && ctl.mem && ctl.rd && (tag == ROM_TAG));
      ram_sel_n = ~(paged && ctl.mem && (tag == RAM_TAG));
      rom_addr  = addr[ROM_AW-1:0];
      ram_addr  = addr[RAM_AW-1:0];
   end
endmodule

// File: rtl/xpg_io_port.sv
module xpg_io_port
   import xpg_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter logic [15:0] PORT_ADDR = 16'h00EF,
   parameter bit          FULL_DEC  = 1'b0,
   parameter logic [7:0]  Q_RESET   = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  xpg_ctl_t          ctl,
   output logic              port_wr_n,
   output logic              port_rd_n,
   output logic [DATA_W-1:0] port_q
);
   logic hit;
   logic io_cyc;

   generate
      if (FULL_DEC) begin : g_full
         assign hit = (addr == PORT_ADDR[ADDR_W-1:0]);
      end else begin : g_low
         assign hit = (addr[7:0] == PORT_ADDR[7:0]);
      end
   endgenerate

   // acknowledge cycles carry IORQ with M1 and are excluded
   always_comb begin
      io_cyc    = ctl.io && !ctl.fetch && hit;
      port_wr_n = ~(io_cyc && ctl.wr);
      port_rd_n = ~(io_cyc && ctl.rd);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          port_q <= DATA_W'(Q_RESET);
      else if (!port_wr_n) port_q <= din;
   end
endmodule

// File: rtl/xpg_decoder.sv
module xpg_decoder
   import xpg_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int          WIN_W     = 13,
   parameter int          ROM_BYTES = 4096,
   parameter int          RAM_BYTES = 2048,
   parameter logic [15:0] PORT_ADDR = 16'h00EF,
   parameter bit          FULL_DEC  = 1'b0,
   localparam int         ROM_AW    = $clog2(ROM_BYTES),
   localparam int         RAM_AW    = $clog2(RAM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              mreq_n,
   input  logic              iorq_n,
   input  logic              m1_n,
   input  logic              rd_n,
   input  logic              wr_n,
   output logic              host_rom_dis,
   output logic              rom_sel_n,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              ram_sel_n,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              port_wr_n,
   output logic              port_rd_n,
   output logic [DATA_W-1:0] port_q
);
   initial begin
      if (ADDR_W != 16) $error("xpg_decoder: address bus must be 16 bits");
   end

   xpg_ctl_t ctl;
   logic     paged;

   assign ctl          = xpg_decode_ctl(mreq_n, iorq_n, m1_n, rd_n, wr_n);
   assign host_rom_dis = paged;

   xpg_fetch_pager #(.ADDR_W(ADDR_W)) u_pager (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ctl(ctl), .paged(paged)
   );

   xpg_mem_sel #(
      .ADDR_W(ADDR_W), .WIN_W(WIN_W), .ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES)
   ) u_mem (
      .paged(paged), .addr(addr), .ctl(ctl),
      .rom_sel_n(rom_sel_n), .rom_addr(rom_addr),
      .ram_sel_n(ram_sel_n), .ram_addr(ram_addr)
   );

   xpg_io_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR), .FULL_DEC(FULL_DEC)
   ) u_io (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ctl(ctl),
      .port_wr_n(port_wr_n), .port_rd_n(port_rd_n), .port_q(port_q)
   );
endmodule

// File: rtl/xpg_decoder_chk.sv
module xpg_decoder_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              mreq_n,
   input logic              iorq_n,
   input logic              m1_n,
   input logic              rd_n,
   input logic              wr_n,
   input logic              host_rom_dis,
   input logic              rom_sel_n,
   input logic              ram_sel_n,
   input logic              port_wr_n,
   input logic              port_rd_n,
   input logic [DATA_W-1:0] port_q
);
   a_r2_page_in: assert property (@(posedge clk) disable iff (!rst_n)
      (!m1_n && !mreq_n && (addr == 16'h0000 || addr == 16'h0008)) |=> host_rom_dis);

   a_r3_page_out: assert property (@(posedge clk) disable iff (!rst_n)
      (!m1_n && !mreq_n && addr == 16'h0604) |=> !host_rom_dis);

   a_r4_no_fetch_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      m1_n |=> $stable(host_rom_dis));

   a_r5_rom_never_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && rd_n) |-> rom_sel_n);

   a_r6_ram_needs_paging: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_sel_n |-> (host_rom_dis && !mreq_n));

   a_r9_ack_not_port: assert property (@(posedge clk) disable iff (!rst_n)
      (!iorq_n && !m1_n) |-> (port_wr_n && port_rd_n));

   a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      port_wr_n |=> $stable(port_q));

   a_r8_wr_needs_io: assert property (@(posedge clk) disable iff (!rst_n)
      !port_wr_n |-> (!iorq_n && !wr_n));
endmodule

bind xpg_decoder xpg_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
   .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n), .host_rom_dis(host_rom_dis),
   .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n), .port_wr_n(port_wr_n),
   .port_rd_n(port_rd_n), .port_q(port_q)
);

// File: tb/test_xpg_decoder.sv
module test_xpg_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = 16'h0;
   logic [7:0]  din = 8'h0;
   logic        mreq_n = 1'b1, iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic        host_rom_dis, rom_sel_n, ram_sel_n, port_wr_n, port_rd_n;
   logic [11:0] rom_addr;
   logic [10:0] ram_addr;
   logic [7:0]  port_q;

   int checks = 0;
   int errors = 0;
   bit m_paged = 0;
   int m_q = 0;

   always #4 clk = ~clk;

   xpg_decoder i_xpg_decoder (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .mreq_n(mreq_n),
      .iorq_n(iorq_n), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
      .host_rom_dis(host_rom_dis), .rom_sel_n(rom_sel_n), .rom_addr(rom_addr),
      .ram_sel_n(ram_sel_n), .ram_addr(ram_addr), .port_wr_n(port_wr_n),
      .port_rd_n(port_rd_n), .port_q(port_q)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // compare all outputs against the behavioural model for the current inputs
   task automatic compare();
      bit rom_exp, ram_exp, pw_exp, pr_exp, port_hit;
      int a = addr;
      rom_exp  = m_paged && !mreq_n && !rd_n && a < 'h2000;              // R5
      ram_exp  = m_paged && !mreq_n && a >= 'h2000 && a < 'h4000;         // R6
      port_hit = (a % 256) == 'hEF;                                        // R7
      pw_exp   = port_hit && !iorq_n && !wr_n && m1_n;                     // R8 R9
      pr_exp   = port_hit && !iorq_n && !rd_n && m1_n;
      chk("R11 host_rom_dis", host_rom_dis, m_paged);
      chk("R5 rom_sel_n", rom_sel_n, !rom_exp);
      chk("R5 rom_addr", rom_addr, a % 4096);
      chk("R6 ram_sel_n", ram_sel_n, !ram_exp);
      chk("R6 ram_addr", ram_addr, a % 2048);
      chk("R8 port_wr_n", port_wr_n, !pw_exp);
      chk("R8 port_rd_n", port_rd_n, !pr_exp);
      chk("R10 port_q", port_q, m_q);
   endtask

   task automatic model_edge();
      int a = addr;
      if (!m1_n && !mreq_n) begin
         if (a == 'h0000 || a == 'h0008) m_paged = 1;   // R2
         else if (a == 'h0604) m_paged = 0;            // R3
      end
      if ((a % 256) == 'hEF && !iorq_n && !wr_n && m1_n) m_q = din;  // R10
   endtask

   // one bus cycle: inputs change after a rising edge, compared at the falling edge
   task automatic cyc(input logic [15:0] a, input logic mq, input logic io,
                      input logic m1, input logic rd, input logic wr, input logic [7:0] d);
      addr = a; mreq_n = mq; iorq_n = io; m1_n = m1; rd_n = rd; wr_n = wr; din = d;
      @(negedge clk);
      compare();
      @(posedge clk);
      model_edge();
      #1;
   endtask

   task automatic fetch(input logic [15:0] a);  cyc(a, 0, 1, 0, 0, 1, 8'h00); endtask
   task automatic mrd(input logic [15:0] a);    cyc(a, 0, 1, 1, 0, 1, 8'h00); endtask
   task automatic mwr(input logic [15:0] a);    cyc(a, 0, 1, 1, 1, 0, 8'h00); endtask
   task automatic iowr(input logic [15:0] a, input logic [7:0] d); cyc(a, 1, 0, 1, 1, 0, d); endtask
   task automatic iord(input logic [15:0] a);   cyc(a, 1, 0, 1, 0, 1, 8'h00); endtask
   task automatic idle();                       cyc(16'h5555, 1, 1, 1, 1, 1, 8'h00); endtask

   initial begin
      #20000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: outputs during reset, with a trap fetch that must be ignored
      addr = 16'h0000; mreq_n = 0; m1_n = 0; rd_n = 0;
      repeat (3) @(negedge clk);
      chk("R1 reset host_rom_dis", host_rom_dis, 0);
      chk("R1 reset rom_sel_n", rom_sel_n, 1);
      chk("R1 reset ram_sel_n", ram_sel_n, 1);
      chk("R1 reset port_q", port_q, 0);
      @(posedge clk); #1;
      mreq_n = 1; m1_n = 1; rd_n = 1;
      rst_n = 1;
      @(posedge clk); #1;

      // R1: mapped out, no selects
      mrd(16'h0100); mrd(16'h2100); mwr(16'h3000);
      // R4: data accesses at trap addresses do not page in
      mrd(16'h0000); mrd(16'h0008); mwr(16'h0000);
      idle();
      chk("R4 still mapped out", host_rom_dis, 0);
      // R2: fetch at 0x0000
      fetch(16'h0000);
      idle();
      chk("R2 paged after fetch 0000", host_rom_dis, 1);
      // R5: ROM reads and mirror, no ROM on write
      mrd(16'h0000); mrd(16'h1234); mrd(16'h1FFF); mwr(16'h0100); fetch(16'h0123);
      // R6: RAM window reads/writes, mirror, outside window
      mrd(16'h2800); mwr(16'h3FFF); mrd(16'h4000); mwr(16'h1FFF);
      // R4: data read at exit address keeps paging
      mrd(16'h0604); mwr(16'h0604);
      idle();
      chk("R4 still paged", host_rom_dis, 1);
      // R7 R8 R10: port
      iowr(16'h12EF, 8'hA5);
      idle();
      chk("R10 port_q captured", port_q, 8'hA5);
      iord(16'hFFEF); iord(16'h00EE); iowr(16'h00FF, 8'h11); iowr(16'h00EE, 8'h22);
      idle();
      chk("R7 other bytes ignored", port_q, 8'hA5);
      // R9: interrupt acknowledge with port address on the bus
      cyc(16'h00EF, 1, 0, 0, 1, 0, 8'h3C);
      cyc(16'h00EF, 1, 0, 0, 0, 1, 8'h3C);
      idle();
      chk("R9 ack left port_q", port_q, 8'hA5);
      // R3: page out; R2 via 0x0008; other fetch does nothing
      fetch(16'h0604);
      idle();
      chk("R3 mapped out after 0604", host_rom_dis, 0);
      mrd(16'h0100);
      fetch(16'h0609); fetch(16'h0208);
      chk("R3 other fetch no change", host_rom_dis, 0);
      fetch(16'h0008);
      idle();
      chk("R2 paged after fetch 0008", host_rom_dis, 1);
      fetch(16'h0008);
      chk("R2 refetch stays", host_rom_dis, 1);

      // random mix, all rules checked every cycle
      for (int i = 0; i < 2000; i++) begin
         logic [15:0] a;
         logic [4:0]  c;
         case ($urandom_range(0, 7))
            0: a = 16'h0000;
            1: a = 16'h0008;
            2: a = 16'h0604;
            3: a = {8'($urandom), 8'hEF};
            4: a = 16'($urandom_range(16'h2000, 16'h3FFF));
            5: a = 16'($urandom_range(0, 16'h1FFF));
            default: a = 16'($urandom);
         endcase
         c = 5'($urandom);
         cyc(a, c[0], c[1], c[2], c[3], c[4], 8'($urandom));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule